// File: doc/BRIEF.md
# Addressed Three-Frame Serial Display Loader

This block receives display contents and display control settings from a host controller over a three-wire serial link made of an enable line, a serial clock and a data line. All three wires, plus a display-off input, are asynchronous to the block's system clock. They are brought into the clock domain through synchronizer stages, and their edges are detected there.

A transfer has two phases. While the enable line is low, the host shifts in an 8-bit device address, least significant bit first. The enable line then goes high and exactly 48 payload bits follow. The final two payload bits form a steering code. That code selects which of three slices of a 105-bit segment image the payload fills. Only the first slice also carries the control settings.

Nothing becomes visible while the bits are arriving. When the enable line falls, a complete frame with a matching address and a valid code is applied to the output registers in a single clock cycle. Any other frame is dropped without a trace.

Top module: `seg_frame_loader`

## Requirements
- R1: After reset, `seg_image`, `port_sel`, `bias_half`, `seg_blank` and `save_mode` are all zero, and `panel_active` equals the inverse of `force_off`.
- R2: While `ser_en` is low, each rising edge of `ser_clk` shifts one address bit in, least significant bit first. A frame is applied only if the last 8 such bits before `ser_en` rises equal 0x46, which arrives as 0,1,1,0,0,0,1,0. Any other address leaves every output unchanged.
- R3: While `ser_en` is high, each rising edge of `ser_clk` takes one payload bit; bits are numbered by arrival from 0. A frame with fewer or more than 48 payload bits leaves every output unchanged.
- R4: Steering code 0,0 (bit 46 = 0, bit 47 = 0) loads segments 0..35 from bits 0..35. The same frame loads `port_sel[3:0]` from bits 39..42, `bias_half` from bit 43, `seg_blank` from bit 44 and `save_mode` from bit 45. Control fields change only through this frame type.
- R5: Steering code 0,1 (bit 46 = 0, bit 47 = 1) loads segments 36..71 from bits 0..35 and leaves the other segments and all control fields unchanged.
- R6: Steering code 1,0 (bit 46 = 1, bit 47 = 0) loads segments 72..104 from bits 0..32 and leaves the rest unchanged. Each frame changes at most one of the three slices.
- R7: Steering code 1,1 is invalid; such a frame leaves every output unchanged.
- R8: Outputs do not change while a frame is being shifted in. An accepted frame updates all of its fields together, in one cycle, only after `ser_en` falls.
- R9: Reception works the same whether `ser_clk` idles low or idles high between bits.
- R10: Frames are accepted while `force_off` is high. `panel_active` is high only when `force_off`, `seg_blank` and `save_mode` are all low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ser_en | input | 1 | Serial enable: low for the address phase, high for the payload phase |
| ser_clk | input | 1 | Serial bit clock, sampled on its rising edge |
| ser_dat | input | 1 | Serial data bit |
| force_off | input | 1 | Display-off request; does not block loading |
| seg_image | output | 105 | Segment image, bit n is segment n |
| port_sel | output | 4 | Port-mode selection field |
| bias_half | output | 1 | Bias selection flag |
| seg_blank | output | 1 | Segment blanking flag |
| save_mode | output | 1 | Power-save flag |
| panel_active | output | 1 | Display shown (not forced off, blanked or saving) |

## Verification
The assertions are checked on every cycle. They require that the payload counter is cleared when the enable line rises and never exceeds its saturation value. They require that the segment image changes only in the cycle after a commit pulse, that a commit pulse appears only on a falling synchronized enable, and that the control fields move only after a commit of the first frame type. They also require that no commit changes more than one image slice.

Some behaviour can only be shown by the bench's scenarios. These are the bit-to-segment mapping of each frame type, rejection of a wrong address, of short and long frames and of the invalid code, correct reception with either clock idle level, and loading while the display is forced off. The bench checks them against a cycle-level reference model.

// File: rtl/seg_loader_pkg.sv
package seg_loader_pkg;

  localparam int          ADDR_W   = 8;
  localparam logic [7:0]  DEV_ADDR = 8'h46;
  localparam int          PAY_W    = 48;
  localparam int          SEG_N    = 105;
  localparam int          PARTS    = 3;
  localparam int          DATA_W   = 36;
  localparam int          CTRL_W   = 7;
  localparam int          CTRL_LSB = 39;
  localparam int          CODE_HI  = 46;
  localparam int          CODE_LO  = 47;
  localparam logic [1:0]  CODE_BAD = 2'b11;
  localparam int          CNT_MAX  = PAY_W + 1;
  localparam int          CNT_W    = $clog2(CNT_MAX + 1);

  // packed so that payload bits 45..39 cast directly (save is the last bit)
  typedef struct packed {
    logic       save;
    logic       blank;
    logic       bias_half;
    logic [3:0] ports;
  } ctrl_t;

  // first segment index covered by slice g
  function automatic int part_off(int g);
    return g * DATA_W;
  endfunction

  // number of segments covered by slice g (last slice takes the remainder)
  function automatic int part_len(int g);
    return (g == PARTS - 1) ? (SEG_N - g * DATA_W) : DATA_W;
  endfunction

  function automatic logic addr_match(logic [ADDR_W-1:0] a);
    return a == DEV_ADDR;
  endfunction

  function automatic logic panel_on(logic off, ctrl_t c);
    return !off && !c.blank && !c.save;
  endfunction

endpackage

// File: rtl/seg_sync.sv
module seg_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] q_out
);

  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d_in;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q_out = stg[STAGES-1];

endmodule

// File: rtl/seg_frame_rx.sv
module seg_frame_rx
  import seg_loader_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_lvl,
  input  logic              sclk_lvl,
  input  logic              dat_lvl,
  output logic              frame_commit,
  output logic [1:0]        frame_code,
  output logic [DATA_W-1:0] frame_data,
  output ctrl_t             frame_ctrl
);

  logic              en_d, sclk_d;
  logic              en_rise, en_fall, sclk_rise;
  logic [ADDR_W-1:0] addr_sr;
  logic              addr_ok;
  logic [PAY_W-1:0]  pay_sr;
  logic [CNT_W-1:0]  bit_cnt;
  logic              cnt_full;

  assign en_rise   = en_lvl & ~en_d;
  assign en_fall   = ~en_lvl & en_d;
  assign sclk_rise = sclk_lvl & ~sclk_d;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_d    <= 1'b0;
      sclk_d  <= 1'b0;
      addr_sr <= '0;
      addr_ok <= 1'b0;
      pay_sr  <= '0;
      bit_cnt <= '0;
    end else begin
      en_d   <= en_lvl;
      sclk_d <= sclk_lvl;
      if (en_rise) begin
        addr_ok <= addr_match(addr_sr);
        bit_cnt <= '0;
      end else if (sclk_rise) begin
        if (en_lvl) begin
          pay_sr <= {dat_lvl, pay_sr[PAY_W-1:1]};
          if (bit_cnt != CNT_W'(CNT_MAX)) bit_cnt <= bit_cnt + 1'b1;
        end else begin
          addr_sr <= {dat_lvl, addr_sr[ADDR_W-1:1]};
        end
      end
    end
  end

  // payload bits 36..38 are fixed filler in every frame type
  logic unused_filler;
  assign unused_filler = ^pay_sr[CTRL_LSB-1:DATA_W];

  assign cnt_full     = (bit_cnt == CNT_W'(PAY_W));
  assign frame_code   = {pay_sr[CODE_HI], pay_sr[CODE_LO]};
  assign frame_data   = pay_sr[DATA_W-1:0];
  assign frame_ctrl   = ctrl_t'(pay_sr[CTRL_LSB +: CTRL_W]);
  assign frame_commit = en_fall & addr_ok & cnt_full & (frame_code != CODE_BAD);

  p_count_cleared_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(en_rise) |-> (bit_cnt == '0));

  p_count_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt <= CNT_W'(CNT_MAX));

endmodule

// File: rtl/seg_image_store.sv
module seg_image_store
  import seg_loader_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              commit,
  input  logic [1:0]        code,
  input  logic [DATA_W-1:0] data,
  input  ctrl_t             ctrl_in,
  output logic [SEG_N-1:0]  image,
  output ctrl_t             ctrl_q
);

  for (genvar g = 0; g < PARTS; g++) begin : g_part
    localparam int OFF = part_off(g);
    localparam int LEN = part_len(g);
    logic [LEN-1:0] part_q;
    always_ff @(posedge clk) begin
      if (!rst_n)                           part_q <= '0;
      else if (commit && code == 2'(g))     part_q <= data[LEN-1:0];
    end
    assign image[OFF +: LEN] = part_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                        ctrl_q <= '0;
    else if (commit && code == 2'd0)   ctrl_q <= ctrl_in;
  end

  p_image_on_commit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (image != $past(image)) |-> $past(commit));

  p_ctrl_frame_a_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q != $past(ctrl_q)) |-> $past(commit && code == 2'd0));

  p_single_part_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({image[part_off(0) +: part_len(0)] != $past(image[part_off(0) +: part_len(0)]),
              image[part_off(1) +: part_len(1)] != $past(image[part_off(1) +: part_len(1)]),
              image[part_off(2) +: part_len(2)] != $past(image[part_off(2) +: part_len(2)])}));

endmodule

// File: rtl/seg_frame_loader.sv
module seg_frame_loader
  import seg_loader_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ser_en,
  input  logic             ser_clk,
  input  logic             ser_dat,
  input  logic             force_off,
  output logic [SEG_N-1:0] seg_image,
  output logic [3:0]       port_sel,
  output logic             bias_half,
  output logic             seg_blank,
  output logic             save_mode,
  output logic             panel_active
);

  logic [3:0]        sync_q;
  logic              en_s, sclk_s, dat_s, off_s;
  logic              frame_commit;
  logic [1:0]        frame_code;
  logic [DATA_W-1:0] frame_data;
  ctrl_t             frame_ctrl;
  ctrl_t             ctrl_q;

  seg_sync #(.W(4), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_in  ({force_off, ser_dat, ser_clk, ser_en}),
    .q_out (sync_q)
  );

  assign {off_s, dat_s, sclk_s, en_s} = sync_q;

  seg_frame_rx u_rx (
    .clk          (clk),
    .rst_n        (rst_n),
    .en_lvl       (en_s),
    .sclk_lvl     (sclk_s),
    .dat_lvl      (dat_s),
    .frame_commit (frame_commit),
    .frame_code   (frame_code),
    .frame_data   (frame_data),
    .frame_ctrl   (frame_ctrl)
  );

  seg_image_store u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .commit  (frame_commit),
    .code    (frame_code),
    .data    (frame_data),
    .ctrl_in (frame_ctrl),
    .image   (seg_image),
    .ctrl_q  (ctrl_q)
  );

  assign port_sel     = ctrl_q.ports;
  assign bias_half    = ctrl_q.bias_half;
  assign seg_blank    = ctrl_q.blank;
  assign save_mode    = ctrl_q.save;
  assign panel_active = panel_on(off_s, ctrl_q);

  p_commit_on_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    frame_commit |-> ($past(en_s) && !en_s));

endmodule

// File: tb/seg_frame_loader_test.sv
module seg_frame_loader_test;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         ser_en = 1'b0, ser_clk = 1'b0, ser_dat = 1'b0, force_off = 1'b0;
  logic [104:0] seg_image;
  logic [3:0]   port_sel;
  logic         bias_half, seg_blank, save_mode, panel_active;

  int checks = 0;
  int errors = 0;
  bit settle = 1'b1;
  bit done   = 1'b0;

  // reference state: e_ctrl = {save, blank, bias, ports[3:0]}
  logic [104:0] e_img  = '0;
  logic [6:0]   e_ctrl = '0;
  logic         e_off  = 1'b0;

  always #10 clk = ~clk;

  seg_frame_loader uut (
    .clk(clk), .rst_n(rst_n), .ser_en(ser_en), .ser_clk(ser_clk), .ser_dat(ser_dat),
    .force_off(force_off), .seg_image(seg_image), .port_sel(port_sel),
    .bias_half(bias_half), .seg_blank(seg_blank), .save_mode(save_mode),
    .panel_active(panel_active)
  );

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [127:0] outs();
    return {seg_image, port_sel, bias_half, seg_blank, save_mode, panel_active};
  endfunction

  function automatic logic [127:0] model_outs();
    logic pa;
    pa = !e_off && !e_ctrl[5] && !e_ctrl[6];
    return {e_img, e_ctrl[3:0], e_ctrl[4], e_ctrl[5], e_ctrl[6], pa};
  endfunction

  // per-cycle comparison against the reference, sampled mid-cycle
  always @(posedge clk) begin
    #5;
    if (rst_n && !settle && !done) chk("R8 per-cycle model", outs(), model_outs());
  end

  function automatic logic [47:0] mk(logic [1:0] code, logic [35:0] d, logic [6:0] c);
    logic [47:0] p;
    p = '0;
    p[35:0] = d;
    if (code == 2'd2) p[35:33] = 3'b000;
    if (code == 2'd0) p[45:39] = c;
    p[46] = code[1];
    p[47] = code[0];
    return p;
  endfunction

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(input logic b, input bit idle_hi);
    if (idle_hi) begin
      ser_clk = 1'b0; ser_dat = b; wait_n(4);
      ser_clk = 1'b1; wait_n(4);
    end else begin
      ser_dat = b; wait_n(4);
      ser_clk = 1'b1; wait_n(4);
      ser_clk = 1'b0;
    end
  endtask

  task automatic send(input logic [7:0] addr, input logic [47:0] p, input int n, input bit idle_hi);
    int code;
    ser_en = 1'b0; ser_clk = idle_hi; wait_n(4);
    for (int i = 0; i < 8; i++) send_bit(addr[i], idle_hi);
    wait_n(4);
    ser_en = 1'b1; wait_n(4);
    for (int i = 0; i < n; i++) send_bit((i < 48) ? p[i] : 1'b1, idle_hi);
    wait_n(6);
    chk("R8 no change before enable falls", outs(), model_outs());
    settle = 1'b1;
    ser_en = 1'b0;
    wait_n(8);
    code = p[46] * 2 + p[47];
    if (addr == 8'h46 && n == 48 && code != 3) begin
      if (code == 0) begin
        for (int k = 0; k < 36; k++) e_img[k] = p[k];
        for (int k = 0; k < 7; k++) e_ctrl[k] = p[39 + k];
      end else if (code == 1) begin
        for (int k = 0; k < 36; k++) e_img[36 + k] = p[k];
      end else begin
        for (int k = 0; k < 33; k++) e_img[72 + k] = p[k];
      end
    end
    settle = 1'b0;
    wait_n(2);
  endtask

  task automatic set_off(input logic v);
    settle = 1'b1;
    force_off = v;
    wait_n(6);
    e_off = v;
    settle = 1'b0;
    wait_n(2);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired before all requirements were exercised");
    finish_run();
  end

  initial begin
    wait_n(5);
    rst_n = 1'b1;
    wait_n(3);
    chk("R1 reset state", outs(), {105'd0, 4'd0, 1'b0, 1'b0, 1'b0, 1'b1});
    settle = 1'b0;

    // R4: first frame type, control fields
    send(8'h46, mk(2'd0, 36'h9A5C3F0E1, 7'b0011010), 48, 1'b0);
    chk("R4 segments 0..35", seg_image[35:0], 36'h9A5C3F0E1);
    chk("R4 port field", port_sel, 4'b1010);
    chk("R4 bias/blank/save", {bias_half, seg_blank, save_mode}, 3'b100);

    // R5: middle slice, control untouched
    send(8'h46, mk(2'd1, 36'h53C96A0F7, 7'b1111111), 48, 1'b0);
    chk("R5 segments 36..71", seg_image[71:36], 36'h53C96A0F7);
    chk("R5 first slice kept", seg_image[35:0], 36'h9A5C3F0E1);
    chk("R5 control kept", {port_sel, bias_half, seg_blank, save_mode}, 7'b1010100);

    // R6 + R9: last slice with clock idling high
    send(8'h46, mk(2'd2, 36'h1DEADBEEF, 7'd0), 48, 1'b1);
    chk("R6 R9 segments 72..104", seg_image[104:72], 33'h1DEADBEEF);
    chk("R6 middle slice kept", seg_image[71:36], 36'h53C96A0F7);

    // R9: first frame type with clock idling high
    send(8'h46, mk(2'd0, 36'h0F0F0F0F0, 7'b0000101), 48, 1'b1);
    chk("R9 idle-high segments 0..35", seg_image[35:0], 36'h0F0F0F0F0);
    chk("R9 idle-high port field", port_sel, 4'b0101);

    // R2: wrong address
    send(8'h47, mk(2'd0, 36'hFFFFFFFFF, 7'b1111111), 48, 1'b0);
    chk("R2 wrong address image", seg_image[35:0], 36'h0F0F0F0F0);
    chk("R2 wrong address control", {port_sel, seg_blank, save_mode}, 6'b010100);
    send(8'h62, mk(2'd1, 36'h000000000, 7'd0), 48, 1'b0);
    chk("R2 bit-reversed address", seg_image[71:36], 36'h53C96A0F7);

    // R3: short and long frames
    send(8'h46, mk(2'd1, 36'h123456789, 7'd0), 47, 1'b0);
    chk("R3 short frame", seg_image[71:36], 36'h53C96A0F7);
    send(8'h46, mk(2'd1, 36'h123456789, 7'd0), 49, 1'b0);
    chk("R3 long frame", seg_image[71:36], 36'h53C96A0F7);

    // R7: invalid steering code
    send(8'h46, mk(2'd3, 36'hAAAAAAAAA, 7'b1111111), 48, 1'b0);
    chk("R7 invalid code image", seg_image, {33'h1DEADBEEF, 36'h53C96A0F7, 36'h0F0F0F0F0});
    chk("R7 invalid code control", {port_sel, bias_half, seg_blank, save_mode}, 7'b0101000);

    // R10: loading while forced off, panel gating
    set_off(1'b1);
    chk("R10 forced off", panel_active, 1'b0);
    send(8'h46, mk(2'd0, 36'h777777777, 7'b0100000), 48, 1'b0);
    chk("R10 load while forced off", seg_image[35:0], 36'h777777777);
    chk("R10 blank loaded", seg_blank, 1'b1);
    set_off(1'b0);
    chk("R10 blank keeps panel dark", panel_active, 1'b0);
    send(8'h46, mk(2'd0, 36'h777777777, 7'b1000000), 48, 1'b0);
    chk("R10 save keeps panel dark", {save_mode, panel_active}, 2'b10);
    send(8'h46, mk(2'd0, 36'h777777777, 7'b0000000), 48, 1'b0);
    chk("R10 panel active", panel_active, 1'b1);

    wait_n(4);
    finish_run();
  end

endmodule